// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs a single channel of a DMA engine. Software loads a source pointer, a destination pointer, a unit count and a control word through a small register port. When the channel is permitted to run and a request is present, the block takes the memory bus. It then moves one unit by reading the source and writing the destination, steps both pointers and counts the remaining units down. It either keeps the bus for the whole job (burst) or gives it back after every unit (cycle steal).

A job ends normally when the count reaches zero. Three sticky flags (end, address error, non-maskable event) block the channel until software writes 0 to them. A one-cycle half-way interrupt marks the point where the count drops to half of the value it held when the channel was enabled. Arbitration between channels and the choice of request source belong to the surrounding logic.

Top module: `dmach_seq`

## Requirements
- R1: A unit moves only while control bit 0 (channel enable), the `glb_en` input and all three flags are clear of blocking: enable bits 1 and flags 0. `mem_rd` and `mem_wr` are never high otherwise.
- R2: Control bits [3:2] pick the request source: 0 automatic, 1 `ext_req`, 2 `per_req`, 3 none. A channel whose selected request is low does not take the bus and keeps its count.
- R3: In automatic mode the bus request rises two clock edges after the enabling control write, with no request input.
- R4: A unit is one `mem_rd` cycle at the source pointer, with `mem_rdata` captured at the end of that cycle, followed by one `mem_wr` cycle at the destination carrying that data. The unit is 2^k bytes, where k is control bits [5:4], and k is shown on `mem_size`. The read waits for `bus_gnt`.
- R5: Every write cycle lowers the count by 1. A job started with count 0 does no bus cycle and ends at once.
- R6: Control bits [7:6] (source) and [9:8] (destination) set the pointer step: 1 adds the unit size, 2 subtracts it, and 0 or 3 leaves the pointer fixed.
- R7: When the channel becomes permitted, it stores the count shifted right by one as the half-way threshold. `irq_half` pulses for one cycle after the write that brings the count to that threshold, if control bit 11 is 1, and at most once until the next capture.
- R8: When the count reaches 0, the end flag (`flags_o[0]`) is set. `irq_end` is high while the end flag and control bit 10 are both 1.
- R9: If either pointer is not aligned to the unit size when a unit would start, the address-error flag (`flags_o[1]`) is set and no bus cycle is made.
- R10: A pulse on `nmi_evt` sets the event flag (`flags_o[2]`) and drops any unit in progress in that same cycle.
- R11: Clearing the channel enable or `glb_en` removes the bus strobes in that cycle and freezes the count. Enabling again continues from the remaining count.
- R12: Control bit 1 = 1 keeps the bus from one unit to the next until the job ends. With bit 1 = 0, `bus_req` falls after every write.
- R13: The flags are sticky. A control write with bit 12 (end), 13 (address error) or 14 (event) at 0 clears that flag, and at 1 leaves it unchanged. While any flag is set the channel does not move.
- R14: `reg_sel` picks 0 source, 1 destination, 2 count, 3 control. After reset all registers, flags and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| glb_en | input | 1 | Global enable shared by all channels |
| ext_req | input | 1 | External request line |
| per_req | input | 1 | On-chip peripheral request line |
| nmi_evt | input | 1 | Non-maskable event pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| cnt_o | output | CW | Remaining unit count |
| flags_o | output | 3 | {event, address error, end} flags |
| irq_half | output | 1 | Half-way interrupt pulse |
| irq_end | output | 1 | End interrupt level |

## Verification
The hardest state to reach is an interruption in the middle of a job. A job has to be stopped with a non-maskable pulse, or by dropping the global enable, while a unit is between its read and its write. It must then be resumed so that the half-way threshold is captured again from the partial count. The stimulus starts long automatic jobs in both bus modes and applies the interruption a fixed number of cycles after the enabling write. A behavioural model follows the job cycle by cycle, so a dropped write, a wrong threshold or a step too many shows up in the cycle where it happens.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } dmach_st_e;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    localparam logic [1:0] RM_AUTO = 2'd0;
    localparam logic [1:0] RM_EXT  = 2'd1;
    localparam logic [1:0] RM_PER  = 2'd2;

    localparam logic [1:0] PM_INC = 2'd1;
    localparam logic [1:0] PM_DEC = 2'd2;

    localparam int TE_BIT = 12;
    localparam int AE_BIT = 13;
    localparam int NF_BIT = 14;
    localparam int CTL_W  = 12;

    typedef struct packed {
        logic       hie;
        logic       ie;
        logic [1:0] dmode;
        logic [1:0] smode;
        logic [1:0] sz;
        logic [1:0] rmode;
        logic       burst;
        logic       en;
    } dmach_ctl_t;

    typedef struct packed {
        logic nf;
        logic ae;
        logic te;
    } dmach_flags_t;

    function automatic logic req_select(logic [1:0] rmode, logic ext, logic per);
        case (rmode)
            RM_AUTO: return 1'b1;
            RM_EXT:  return ext;
            RM_PER:  return per;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dmach_addr_unit.sv
module dmach_addr_unit import dmach_pkg::*; #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    sz_i,
    output logic [AW-1:0] nxt_o,
    output logic          misal_o
);
    logic [AW-1:0] ubytes;

    assign ubytes  = AW'(1) << sz_i;
    assign misal_o = |(addr_i & (ubytes - AW'(1)));

    always_comb begin
        case (mode_i)
            PM_INC:  nxt_o = addr_i + ubytes;
            PM_DEC:  nxt_o = addr_i - ubytes;
            default: nxt_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm import dmach_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic req_hit,
    input  logic misal,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic burst,
    input  logic bus_gnt,
    output logic set_te,
    output logic set_ae,
    output logic bus_req,
    output logic mem_rd,
    output logic mem_wr
);
    dmach_st_e st, nxt;

    always_comb begin
        nxt    = st;
        set_te = 1'b0;
        set_ae = 1'b0;
        if (!go) begin
            nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (req_hit) begin
                    if (cnt_zero)   set_te = 1'b1;
                    else if (misal) set_ae = 1'b1;
                    else            nxt    = ST_ARB;
                end
                ST_ARB: if (bus_gnt) nxt = ST_RD;
                ST_RD:  nxt = ST_WR;
                ST_WR: begin
                    if (cnt_one) begin
                        set_te = 1'b1;
                        nxt    = ST_IDLE;
                    end else begin
                        nxt = burst ? ST_RD : ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    assign bus_req = go && (st != ST_IDLE);
    assign mem_rd  = go && (st == ST_RD);
    assign mem_wr  = go && (st == ST_WR);

    // R12
    steal_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !burst) |=> !bus_req);

    // R4
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(go) && go) |-> !$past(mem_wr) || burst);
endmodule

// File: rtl/dmach_half.sv
module dmach_half #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          perm,
    input  logic          step,
    input  logic          hie,
    input  logic [CW-1:0] cnt,
    output logic          irq_half
);
    logic [CW-1:0] thr;
    logic          hdone;
    logic          perm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr      <= '0;
            hdone    <= 1'b0;
            perm_q   <= 1'b0;
            irq_half <= 1'b0;
        end else begin
            perm_q   <= perm;
            irq_half <= 1'b0;
            if (perm && !perm_q) begin
                thr   <= cnt >> 1;
                hdone <= 1'b0;
            end else if (step && (cnt - CW'(1)) == thr && !hdone) begin
                hdone    <= 1'b1;
                irq_half <= hie;
            end
        end
    end

    // R7
    half_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_half |=> !irq_half);
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq import dmach_pkg::*; #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          glb_en,
    input  logic          ext_req,
    input  logic          per_req,
    input  logic          nmi_evt,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [CW-1:0] cnt_o,
    output logic [2:0]    flags_o,
    output logic          irq_half,
    output logic          irq_end
);
    localparam int NPTR = 2;

    dmach_ctl_t    ctl;
    dmach_flags_t  flg;
    logic [AW-1:0] src, dst;
    logic [CW-1:0] cnt;
    logic [DW-1:0] buf_q;
    logic          perm, go, req_hit, set_te, set_ae, ctl_wr;
    logic [AW-1:0] a_cur [NPTR];
    logic [AW-1:0] a_nxt [NPTR];
    logic [1:0]    a_mode[NPTR];
    logic          a_mis [NPTR];

    assign a_cur[0]  = src;
    assign a_cur[1]  = dst;
    assign a_mode[0] = ctl.smode;
    assign a_mode[1] = ctl.dmode;

    generate
        for (genvar g = 0; g < NPTR; g++) begin : g_ptr
            dmach_addr_unit #(.AW(AW)) u_au (
                .addr_i (a_cur[g]),
                .mode_i (a_mode[g]),
                .sz_i   (ctl.sz),
                .nxt_o  (a_nxt[g]),
                .misal_o(a_mis[g])
            );
        end
    endgenerate

    assign perm    = ctl.en && glb_en && (flg == '0);
    assign go      = perm && !nmi_evt;
    assign req_hit = req_select(ctl.rmode, ext_req, per_req);
    assign ctl_wr  = reg_we && (reg_sel == SEL_CTL);

    dmach_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .req_hit (req_hit),
        .misal   (a_mis[0] || a_mis[1]),
        .cnt_zero(cnt == '0),
        .cnt_one (cnt == CW'(1)),
        .burst   (ctl.burst),
        .bus_gnt (bus_gnt),
        .set_te  (set_te),
        .set_ae  (set_ae),
        .bus_req (bus_req),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr)
    );

    dmach_half #(.CW(CW)) u_half (
        .clk     (clk),
        .rst     (rst),
        .perm    (perm),
        .step    (mem_wr),
        .hie     (ctl.hie),
        .cnt     (cnt),
        .irq_half(irq_half)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            flg   <= '0;
            src   <= '0;
            dst   <= '0;
            cnt   <= '0;
            buf_q <= '0;
        end else begin
            if (mem_rd) buf_q <= mem_rdata;
            if (mem_wr) begin
                cnt <= cnt - CW'(1);
                src <= a_nxt[0];
                dst <= a_nxt[1];
            end
            flg.te <= (ctl_wr ? (flg.te & reg_wdata[TE_BIT]) : flg.te) | set_te;
            flg.ae <= (ctl_wr ? (flg.ae & reg_wdata[AE_BIT]) : flg.ae) | set_ae;
            flg.nf <= (ctl_wr ? (flg.nf & reg_wdata[NF_BIT]) : flg.nf) | nmi_evt;
            if (reg_we) begin
                case (reg_sel)
                    SEL_SRC: src <= reg_wdata[AW-1:0];
                    SEL_DST: dst <= reg_wdata[AW-1:0];
                    SEL_CNT: cnt <= reg_wdata[CW-1:0];
                    default: ctl <= dmach_ctl_t'(reg_wdata[CTL_W-1:0]);
                endcase
            end
        end
    end

    assign mem_addr  = mem_rd ? src : dst;
    assign mem_size  = ctl.sz;
    assign mem_wdata = buf_q;
    assign cnt_o     = cnt;
    assign flags_o   = flg;
    assign irq_end   = flg.te && ctl.ie;

    // R1
    gate_open_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (ctl.en && glb_en && flg == '0));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !reg_we) |=> (cnt == $past(cnt) - CW'(1)));

    // R10
    nmi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_evt |=> flg.nf);

    // R9
    align_nobus_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.ae) |-> !$past(bus_req));
endmodule

// File: tb/dmach_seq_tb.sv
module dmach_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        glb_en = 1'b1, ext_req = 1'b0, per_req = 1'b0, nmi_evt = 1'b0;
    logic        bus_gnt = 1'b1;
    logic        bus_req, mem_rd, mem_wr, irq_half, irq_end;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic [15:0] cnt_o;
    logic [2:0]  flags_o;

    always #5 clk = ~clk;

    assign mem_rdata = mem_addr * 32'd3 + 32'd7;

    dmach_seq u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .glb_en(glb_en), .ext_req(ext_req), .per_req(per_req), .nmi_evt(nmi_evt),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cnt_o(cnt_o), .flags_o(flags_o),
        .irq_half(irq_half), .irq_end(irq_end)
    );

    int vecs = 0;
    int errs = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit [31:0] m_src, m_dst, m_buf;
    bit [15:0] m_cnt, m_thr;
    bit        m_en, m_burst, m_ie, m_hie, m_te, m_ae, m_nf, m_hdone, m_pq, m_half;
    bit [1:0]  m_rm, m_sz, m_sm, m_dm;
    int        m_ph;

    function automatic bit [31:0] adv(bit [31:0] a, bit [1:0] m, bit [31:0] u);
        if (m == 2'd1) return a + u;
        if (m == 2'd2) return a - u;
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_src = 0; m_dst = 0; m_buf = 0; m_cnt = 0; m_thr = 0;
            m_en = 0; m_burst = 0; m_ie = 0; m_hie = 0; m_te = 0; m_ae = 0; m_nf = 0;
            m_hdone = 0; m_pq = 0; m_half = 0; m_rm = 0; m_sz = 0; m_sm = 0; m_dm = 0;
            m_ph = 0;
        end else begin
            bit [31:0] ub;
            bit perm_m, go_m, hit, mis, t_set, a_set, nhalf, w;
            int nph;
            ub     = 32'd1 << m_sz;
            perm_m = m_en && glb_en && !m_te && !m_ae && !m_nf;
            go_m   = perm_m && !nmi_evt;
            hit    = (m_rm == 0) || (m_rm == 1 && ext_req) || (m_rm == 2 && per_req);
            mis    = (m_src % ub != 0) || (m_dst % ub != 0);
            t_set = 0; a_set = 0; nhalf = 0; nph = m_ph;
            if (perm_m && !m_pq) begin
                m_thr = m_cnt >> 1;
                m_hdone = 0;
            end
            m_pq = perm_m;
            if (!go_m) nph = 0;
            else if (m_ph == 0) begin
                if (hit) begin
                    if (m_cnt == 0) t_set = 1;
                    else if (mis) a_set = 1;
                    else nph = 1;
                end
            end else if (m_ph == 1) begin
                if (bus_gnt) nph = 2;
            end else if (m_ph == 2) begin
                m_buf = m_src * 3 + 7;
                nph = 3;
            end else begin
                if (m_cnt - 16'd1 == m_thr && !m_hdone) begin
                    m_hdone = 1;
                    nhalf = m_hie;
                end
                m_cnt = m_cnt - 16'd1;
                m_src = adv(m_src, m_sm, ub);
                m_dst = adv(m_dst, m_dm, ub);
                if (m_cnt == 0) begin t_set = 1; nph = 0; end
                else nph = m_burst ? 2 : 0;
            end
            m_half = nhalf;
            w = reg_we && reg_sel == 2'd3;
            m_te = (w ? (m_te & reg_wdata[12]) : m_te) | t_set;
            m_ae = (w ? (m_ae & reg_wdata[13]) : m_ae) | a_set;
            m_nf = (w ? (m_nf & reg_wdata[14]) : m_nf) | nmi_evt;
            if (reg_we) begin
                case (reg_sel)
                    2'd0: m_src = reg_wdata;
                    2'd1: m_dst = reg_wdata;
                    2'd2: m_cnt = reg_wdata[15:0];
                    default: begin
                        m_en = reg_wdata[0]; m_burst = reg_wdata[1]; m_rm = reg_wdata[3:2];
                        m_sz = reg_wdata[5:4]; m_sm = reg_wdata[7:6]; m_dm = reg_wdata[9:8];
                        m_ie = reg_wdata[10]; m_hie = reg_wdata[11];
                    end
                endcase
            end
            m_ph = nph;
        end
    end

    bit cmp_on = 0;

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            bit go_e, e_rd, e_wr;
            go_e = m_en && glb_en && !m_te && !m_ae && !m_nf && !nmi_evt;
            e_rd = go_e && m_ph == 2;
            e_wr = go_e && m_ph == 3;
            chk(bus_req == (go_e && m_ph != 0), "R12 bus_req", bus_req, go_e && m_ph != 0);
            chk(mem_rd == e_rd, "R4 mem_rd", mem_rd, e_rd);
            chk(mem_wr == e_wr, "R4 mem_wr", mem_wr, e_wr);
            if (e_rd) chk(mem_addr == m_src, "R6 src addr", mem_addr, m_src);
            if (e_wr) chk(mem_addr == m_dst, "R6 dst addr", mem_addr, m_dst);
            if (e_wr) chk(mem_wdata == m_buf, "R4 wdata", mem_wdata, m_buf);
            if (e_rd || e_wr) chk(mem_size == m_sz, "R4 size", mem_size, m_sz);
            chk(cnt_o == m_cnt, "R5 count", cnt_o, m_cnt);
            chk(flags_o == {m_nf, m_ae, m_te}, "R13 flags", flags_o, {m_nf, m_ae, m_te});
            chk(irq_half == m_half, "R7 irq_half", irq_half, m_half);
            chk(irq_end == (m_te && m_ie), "R8 irq_end", irq_end, m_te && m_ie);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] mk(bit en, bit burst, bit [1:0] rm, bit [1:0] sz,
                                       bit [1:0] sm, bit [1:0] dm, bit ie, bit hie, bit keep);
        return {17'd0, keep, keep, keep, hie, ie, dm, sm, sz, rm, burst, en};
    endfunction

    task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c);
        wr(2'd0, s); wr(2'd1, d); wr(2'd2, {16'd0, c});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    initial begin
        logic [15:0] held;
        tick(3);
        rst = 1'b0;
        cmp_on = 1;
        // R14 reset state
        chk(flags_o == 3'd0 && cnt_o == 16'd0 && !bus_req, "R14 reset", {flags_o, cnt_o}, 0);

        // R3 auto burst, word units, both incrementing
        load(32'h100, 32'h200, 16'd6);
        wr(2'd3, mk(1, 1, 0, 2, 1, 1, 1, 1, 0));
        tick(1);
        chk(bus_req == 1'b1, "R3 auto start", bus_req, 1);
        tick(30);
        chk(flags_o == 3'b001, "R8 end flag", flags_o, 3'b001);
        chk(irq_end == 1'b1, "R8 irq_end", irq_end, 1);

        // R13 restart blocked while end flag kept
        wr(2'd2, 32'd3);
        wr(2'd3, mk(1, 1, 0, 2, 1, 1, 1, 1, 1));
        tick(10);
        chk(cnt_o == 16'd3, "R13 blocked", cnt_o, 3);
        chk(!bus_req, "R1 no bus", bus_req, 0);
        wr(2'd3, 32'd0);
        chk(flags_o == 3'd0, "R13 clear", flags_o, 0);

        // R2 external, cycle steal, half units, src inc dst dec, late grant
        load(32'h1000, 32'h3000, 16'd4);
        bus_gnt = 1'b0;
        wr(2'd3, mk(1, 0, 1, 1, 1, 2, 1, 1, 0));
        tick(5);
        chk(cnt_o == 16'd4, "R2 no request", cnt_o, 4);
        ext_req = 1'b1;
        tick(4);
        chk(cnt_o == 16'd4, "R4 waits grant", cnt_o, 4);
        bus_gnt = 1'b1;
        tick(30);
        ext_req = 1'b0;
        chk(flags_o == 3'b001, "R12 steal end", flags_o, 1);
        wr(2'd3, 32'd0);

        // R7 peripheral, fixed pointers, byte unit, count 1
        load(32'h55, 32'h77, 16'd1);
        wr(2'd3, mk(1, 0, 2, 0, 0, 3, 1, 1, 0));
        tick(3);
        per_req = 1'b1;
        tick(8);
        per_req = 1'b0;
        chk(flags_o == 3'b001, "R7 single unit end", flags_o, 1);
        wr(2'd3, 32'd0);

        // R9 misaligned source
        load(32'h102, 32'h200, 16'd5);
        wr(2'd3, mk(1, 1, 0, 2, 1, 1, 0, 0, 0));
        tick(6);
        chk(flags_o == 3'b010, "R9 align flag", flags_o, 2);
        chk(cnt_o == 16'd5, "R9 count kept", cnt_o, 5);
        wr(2'd3, 32'd0);

        // R10 event mid burst
        load(32'h400, 32'h800, 16'd10);
        wr(2'd3, mk(1, 1, 0, 2, 1, 1, 1, 1, 0));
        tick(5);
        nmi_evt = 1'b1;
        tick(1);
        nmi_evt = 1'b0;
        held = cnt_o;
        tick(5);
        chk(flags_o == 3'b100, "R10 event flag", flags_o, 4);
        chk(cnt_o == held && held != 0, "R10 stopped", cnt_o, held);
        wr(2'd3, 32'd0);

        // R11 global enable drop and resume
        load(32'h2000, 32'h2100, 16'd8);
        wr(2'd3, mk(1, 0, 0, 2, 1, 1, 1, 1, 0));
        tick(7);
        glb_en = 1'b0;
        tick(1);
        held = cnt_o;
        tick(5);
        chk(cnt_o == held, "R11 frozen", cnt_o, held);
        glb_en = 1'b1;
        tick(40);
        chk(flags_o == 3'b001, "R11 resumed", flags_o, 1);
        wr(2'd3, 32'd0);

        // R5 zero count
        wr(2'd2, 32'd0);
        wr(2'd3, mk(1, 1, 0, 0, 1, 1, 1, 0, 0));
        tick(3);
        chk(flags_o == 3'b001, "R5 zero count", flags_o, 1);
        wr(2'd3, 32'd0);

        // R2 mode 3 never requests
        wr(2'd2, 32'd5);
        wr(2'd3, mk(1, 1, 3, 0, 1, 1, 0, 0, 0));
        tick(10);
        chk(cnt_o == 16'd5, "R2 none mode", cnt_o, 5);

        // R6 decrement both with word units, channel enable drop
        load(32'h900, 32'hA00, 16'd7);
        wr(2'd3, mk(1, 1, 0, 2, 2, 2, 0, 1, 0));
        tick(6);
        wr(2'd3, mk(0, 1, 0, 2, 2, 2, 0, 1, 1));
        held = cnt_o;
        tick(4);
        chk(cnt_o == held, "R11 chan off", cnt_o, held);
        wr(2'd3, mk(1, 1, 0, 2, 2, 2, 0, 1, 1));
        tick(30);
        chk(cnt_o == 16'd0, "R6 dec done", cnt_o, 0);

        finish_run();
    end
endmodule